// File: doc/BRIEF.md
# Prioritized Interrupt State Vector Register

This block gathers the pending events of a serial data link controller into one read-only vector byte. Each of eight event sources has a sticky pending flag that a one-cycle pulse sets. The block encodes the highest pending source as a 4-bit code and places it in bits 5..2 of the byte. Software can then use the byte directly as an offset into a jump table of service routines. An interrupt request line stays high while any flag is pending.

A vector read clears the reported source immediately, with three exceptions. The two receive sources and the transmit-empty source are data-register services, and each needs a two-access sequence before it clears. A vector read that returns one of them arms a clear. The matching data-register access then completes it: a read for the receive sources, or a write for transmit-empty. Transmit-empty also clears while the end-of-transmit-data control input is high.

Top module: `intvec_reg`

## Requirements
- R1: After reset, the vector byte reads 0x00 and the interrupt request is low.
- R2: The vector byte holds the source code in bits 5..2, and bits 7, 6, 1 and 0 read 0. The byte is loaded only in a cycle with the vector read strobe, and it holds its value in every other cycle.
- R3: An event pulse on input bit i sets the pending flag for code i+1. The codes are: 1 end-of-frame received, 2 in-frame-response byte, 3 receive data full, 4 transmit data empty, 5 arbitration lost, 6 CRC error, 7 bad symbol, 8 wakeup. A vector read loads the highest pending code, or 0 when nothing is pending.
- R4: A vector read clears the reported flag when its code is 1, 5, 6, 7 or 8.
- R5: A vector read leaves the reported flag set when its code is 2, 3 or 4.
- R6: A vector read that returns code 2 or 3, followed by a data-register read, clears only that flag.
- R7: A vector read that returns code 4, followed by a data-register write, clears flag 4. A high end-of-transmit-data input also clears flag 4 in any cycle.
- R8: A data-register access clears nothing unless a vector read has armed the sequence. Any data-register access disarms the sequence, and so does the next vector read (which arms again only for its own result). A read after an arm for code 4, or a write after an arm for code 2 or 3, disarms without clearing.
- R9: When an event pulse and a clear for the same flag fall in one cycle, the flag stays set.
- R10: The interrupt request is high exactly when at least one flag is pending.
- R11: After the reported source clears, the next vector read returns the next highest pending code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Event pulses; bit i sets code i+1 |
| vec_rd | input | 1 | Vector register read strobe |
| dat_rd | input | 1 | Data register read strobe |
| dat_wr | input | 1 | Data register write strobe |
| tx_end | input | 1 | End-of-transmit-data control bit |
| vec_q | output | 8 | Vector byte, code in bits 5..2 |
| irq | output | 1 | Interrupt request |

## Verification
The event that sets a flag can arrive in the same cycle as the vector read or data-register access that clears it. Directed cases pulse the bad-symbol event during its own clearing vector read. They also pulse the receive-full event during the data read that completes its two-step clear. A later vector read must still report each source. Random traffic also produces these collisions, and a bench reference model judges each one with set-over-clear priority.

// File: rtl/intvec_reg.sv
module intvec_reg #(
  parameter int NSRC = 8,
  parameter int CW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            vec_rd,
  input  logic            dat_rd,
  input  logic            dat_wr,
  input  logic            tx_end,
  output logic [7:0]      vec_q,
  output logic            irq
);
  localparam logic [CW-1:0] C_IFR = CW'(2);
  localparam logic [CW-1:0] C_RXF = CW'(3);
  localparam logic [CW-1:0] C_TXE = CW'(4);

  logic [NSRC-1:0] pend, clr;
  logic [CW-1:0]   top, arm;
  logic            top_dat;

  always_comb begin
    top = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend[i]) top = CW'(i + 1);
  end

  assign top_dat = (top == C_IFR) || (top == C_RXF) || (top == C_TXE);
  assign irq = |pend;

  always_comb begin
    clr = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (vec_rd && !top_dat && top == CW'(i + 1)) clr[i] = 1'b1;
      if (dat_rd && (arm == C_IFR || arm == C_RXF) && arm == CW'(i + 1)) clr[i] = 1'b1;
      if ((dat_wr && arm == C_TXE || tx_end) && C_TXE == CW'(i + 1)) clr[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      arm   <= '0;
      vec_q <= 8'h00;
    end else begin
      pend <= (pend & ~clr) | evt_i;
      if (vec_rd) begin
        vec_q <= {2'b00, top, 2'b00};
        arm   <= top_dat ? top : '0;
      end else if (dat_rd || dat_wr) begin
        arm <= '0;
      end
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_rd |=> $stable(vec_q));
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend & $past(evt_i)) == $past(evt_i)));
  a_r4_wake_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && top == CW'(8) && !evt_i[7]) |=> !pend[7]);
  a_r5_rxf_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && top == C_RXF && !dat_rd) |=> pend[2]);
  a_r8_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !vec_rd && arm == '0 && pend[2]) |=> pend[2]);
  a_r10_irq_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && top != '0) |-> irq);
endmodule

// File: tb/test_intvec_reg.sv
module test_intvec_reg;
  localparam int PER = 10;
  logic clk = 0, rst_n = 0;
  logic [7:0] evt_i = 0;
  logic vec_rd = 0, dat_rd = 0, dat_wr = 0, tx_end = 0;
  logic [7:0] vec_q;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] m_pend = 0, m_vec = 0;
  logic [3:0] m_arm = 0;

  always #(PER/2) clk = ~clk;

  intvec_reg i_intvec_reg (.clk(clk), .rst_n(rst_n), .evt_i(evt_i), .vec_rd(vec_rd),
    .dat_rd(dat_rd), .dat_wr(dat_wr), .tx_end(tx_end), .vec_q(vec_q), .irq(irq));

  function automatic logic [3:0] hi_code(logic [7:0] p);
    logic [3:0] c = 0;
    for (int i = 0; i < 8; i++) if (p[i]) c = 4'(i + 1);
    return c;
  endfunction

  function automatic bit is_dat(logic [3:0] c);
    return c == 2 || c == 3 || c == 4;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [7:0] ev, logic vr, logic dr, logic dw, logic te);
    logic [3:0] t;
    logic [7:0] c;
    evt_i = ev; vec_rd = vr; dat_rd = dr; dat_wr = dw; tx_end = te;
    t = hi_code(m_pend);
    c = 0;
    if (vr && t != 0 && !is_dat(t)) c[t-1] = 1;
    if (dr && (m_arm == 2 || m_arm == 3)) c[m_arm-1] = 1;
    if ((dw && m_arm == 4) || te) c[3] = 1;
    @(posedge clk);
    m_pend = (m_pend & ~c) | ev;
    if (vr) begin m_vec = {2'b00, t, 2'b00}; m_arm = is_dat(t) ? t : 4'd0; end
    else if (dr || dw) m_arm = 0;
    @(negedge clk);
    chk("R3 model vec", vec_q, m_vec);
    chk("R10 model irq", {7'b0, irq}, {7'b0, m_pend != 0});
  endtask

  task automatic rd(logic [7:0] exp, string tag);
    cyc(0, 1, 0, 0, 0);
    chk(tag, vec_q, exp);
  endtask

  initial begin
    repeat (PER * 200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    chk("R1 reset vec", vec_q, 8'h00);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1;
    // R3 R11 priority, R4 clear
    cyc(8'h81, 0, 0, 0, 0);
    chk("R10 irq set", {7'b0, irq}, 8'h01);
    cyc(0, 0, 0, 0, 0);
    chk("R2 hold without read", vec_q, 8'h00);
    rd(8'h20, "R3 wakeup highest");
    rd(8'h04, "R4 R11 next after wake clear");
    rd(8'h00, "R4 eof cleared");
    chk("R10 irq low", {7'b0, irq}, 8'h00);
    // R8 unarmed data access, R5, R6
    cyc(8'h04, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    rd(8'h0C, "R8 unarmed read keeps rxf");
    rd(8'h0C, "R5 vec read keeps rxf");
    cyc(0, 0, 1, 0, 0);
    rd(8'h00, "R6 rxf cleared");
    // R8 disarm by write
    cyc(8'h04, 0, 0, 0, 0);
    rd(8'h0C, "R3 rxf code");
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 1, 0, 0);
    rd(8'h0C, "R8 disarmed by write");
    cyc(0, 0, 1, 0, 0);
    rd(8'h00, "R6 rxf cleared after rearm");
    // R6 only reported one, R11
    cyc(8'h06, 0, 0, 0, 0);
    rd(8'h0C, "R3 rxf over ifr");
    cyc(0, 0, 1, 0, 0);
    rd(8'h08, "R6 R11 ifr remains");
    cyc(0, 0, 1, 0, 0);
    rd(8'h00, "R6 ifr cleared");
    // R7
    cyc(8'h08, 0, 0, 0, 0);
    rd(8'h10, "R3 txe code");
    cyc(0, 0, 0, 1, 0);
    rd(8'h00, "R7 txe cleared by write");
    cyc(8'h08, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    rd(8'h00, "R7 txe cleared by tx_end");
    // R9 collisions
    cyc(8'h40, 0, 0, 0, 0);
    cyc(8'h40, 1, 0, 0, 0);
    chk("R9 sym read", vec_q, 8'h1C);
    rd(8'h1C, "R9 set wins over read clear");
    rd(8'h00, "R4 sym cleared");
    cyc(8'h04, 0, 0, 0, 0);
    rd(8'h0C, "R3 rxf again");
    cyc(8'h04, 0, 1, 0, 0);
    rd(8'h0C, "R9 set wins over data clear");
    cyc(0, 0, 1, 0, 0);
    rd(8'h00, "R6 cleared");
    // random
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] ev = 0;
      for (int b = 0; b < 8; b++) if ($urandom_range(0, 19) == 0) ev[b] = 1;
      cyc(ev, $urandom_range(0, 2) == 0, $urandom_range(0, 5) == 0,
          $urandom_range(0, 5) == 0, $urandom_range(0, 19) == 0);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule